// File: doc/BRIEF.md
# Burst-of-Two Dual-Port RAM with Collision Forwarding

This block is a behavioural memory with a separate read port and write port. Each port moves a burst of two beats per access. On a double-data-rate device the two beats travel on the two clock edges; here they are presented side by side as beat 0 and beat 1. One read and one write can be issued in the same clock cycle. Each is selected by its own active-low strobe and has its own address.

Writes are qualified byte by byte. They sit in a one-stage pending register and reach the array one cycle after they are issued. Read data returns a fixed two cycles after the read command, together with a valid flag.

Address collisions are resolved so that a read never returns stale contents:
- A read of an address whose write is still pending sees that write.
- A read and a write to the same address in the same cycle return the incoming write beats directly.
- In both cases, bytes that are masked off on the write come from the stored word.

Top module: `burst2_dualport_ram`

## Requirements
- R1: While reset is held and on the first cycle after release, `rd_valid` is 0 and both read beats are 0.
- R2: A read issued with `rd_n` low before clock edge E raises `rd_valid` after edge E+1 for exactly one cycle. Reads may be issued on every cycle.
- R3: Whenever `rd_valid` is 0, `rd_data0` and `rd_data1` are 0.
- R4: A write stores `wr_data0` as beat 0 and `wr_data1` as beat 1 of the addressed word. A later read returns them on `rd_data0` and `rd_data1`.
- R5: Each beat is split into two 9-bit bytes. Byte i is bits [9i+8:9i]. `wr_be0[i]` enables byte i of beat 0 and `wr_be1[i]` enables byte i of beat 1. A byte whose enable is 0 keeps its previous value.
- R6: A read issued on the cycle after a write to the same address returns the newly written data, merged per R5.
- R7: A read and a write to the same address in the same cycle return the incoming write data. Bytes with enable 0 come from the stored word, so the result equals the word the write leaves behind.
- R8: A read and a write to different addresses in the same cycle do not interact. The read returns the stored data and the write is stored.
- R9: With `wr_n` high the array is unchanged, whatever the data and enables. With `rd_n` high no valid data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline state |
| rd_n | input | 1 | Active-low read select |
| rd_addr | input | 6 | Read address |
| wr_n | input | 1 | Active-low write select |
| wr_addr | input | 6 | Write address |
| wr_data0 | input | 18 | Write beat 0 |
| wr_data1 | input | 18 | Write beat 1 |
| wr_be0 | input | 2 | Byte enables for beat 0 |
| wr_be1 | input | 2 | Byte enables for beat 1 |
| rd_valid | output | 1 | Read data valid, two cycles after the read |
| rd_data0 | output | 18 | Read beat 0 |
| rd_data1 | output | 18 | Read beat 1 |

## Verification
The bench targets the three collision windows, each across every address:
- **Same-cycle hit.** A design that read the array here would return the old word instead of the incoming beats.
- **Next-cycle hit on a write that is still pending.** A design that skipped the pending register would return data one write behind.
- **Partially masked write in either window.** A design that forwarded the raw write beats would return garbage in the masked-off bytes.

All sixteen enable patterns are swept. Writes with the strobe high but enables set are issued to catch a design that ignores the select. Back-to-back reads are used to expose a latency or valid-width error.

// File: rtl/burst2_dualport_ram.sv
module burst2_dualport_ram #(
  parameter int AW     = 6,
  parameter int BEAT_W = 18,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic [AW-1:0]     rd_addr,
  input  logic              wr_n,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BEAT_W-1:0] wr_data0,
  input  logic [BEAT_W-1:0] wr_data1,
  input  logic [NBYTES-1:0] wr_be0,
  input  logic [NBYTES-1:0] wr_be1,
  output logic              rd_valid,
  output logic [BEAT_W-1:0] rd_data0,
  output logic [BEAT_W-1:0] rd_data1
);
  localparam int DEPTH  = 1 << AW;
  localparam int BYTE_W = BEAT_W / NBYTES;
  localparam int WORD_W = 2 * BEAT_W;
  localparam int MASK_W = 2 * NBYTES;

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old_w,
                                               input logic [WORD_W-1:0] new_w,
                                               input logic [MASK_W-1:0] m);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int i = 0; i < MASK_W; i++)
      if (m[i]) r[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];

  logic              pend_v;
  logic [AW-1:0]     pend_a;
  logic [WORD_W-1:0] pend_d;
  logic [MASK_W-1:0] pend_m;

  logic              s1_v;
  logic [WORD_W-1:0] s1_d;
  logic [WORD_W-1:0] out_d;

  wire               wr_go   = !wr_n;
  wire               rd_go   = !rd_n;
  wire [WORD_W-1:0]  wr_word = {wr_data1, wr_data0};
  wire [MASK_W-1:0]  wr_mask = {wr_be1, wr_be0};

  wire [WORD_W-1:0]  arr_word = mem[rd_addr];
  wire [WORD_W-1:0]  via_pend = (pend_v && pend_a == rd_addr) ? merge(arr_word, pend_d, pend_m) : arr_word;
  wire [WORD_W-1:0]  via_now  = (wr_go && wr_addr == rd_addr) ? merge(via_pend, wr_word, wr_mask) : via_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
      pend_m <= '0;
    end else begin
      pend_v <= wr_go;
      if (wr_go) begin
        pend_a <= wr_addr;
        pend_d <= wr_word;
        pend_m <= wr_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MASK_W; i++)
      if (pend_v && rst_n && pend_m[i])
        mem[pend_a][i*BYTE_W +: BYTE_W] <= pend_d[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_d     <= '0;
      rd_valid <= 1'b0;
      out_d    <= '0;
    end else begin
      s1_v     <= rd_go;
      s1_d     <= rd_go ? via_now : '0;
      rd_valid <= s1_v;
      out_d    <= s1_d;
    end
  end

  assign rd_data0 = out_d[BEAT_W-1:0];
  assign rd_data1 = out_d[WORD_W-1:BEAT_W];

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> ##1 rd_valid);

  a_r2_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> ##1 !rd_valid);

  a_r3_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data0 == '0 && rd_data1 == '0));

  a_r7_pass_thru: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n && rd_addr == wr_addr && (&wr_be0) && (&wr_be1))
      |=> ##1 ({rd_data1, rd_data0} == $past({wr_data1, wr_data0}, 2)));

  a_r6_raw_next: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wr_n && (&wr_be0) && (&wr_be1))
      ##1 (!rd_n && rd_addr == $past(wr_addr) && (wr_n || wr_addr != rd_addr)))
      |=> ##1 ({rd_data1, rd_data0} == $past({wr_data1, wr_data0}, 3)));
endmodule

// File: tb/sim_burst2_dualport_ram.sv
`timescale 1ns/1ps
module sim_burst2_dualport_ram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_n = 1'b1, wr_n = 1'b1;
  logic [5:0]  rd_addr = '0, wr_addr = '0;
  logic [17:0] wr_data0 = '0, wr_data1 = '0;
  logic [1:0]  wr_be0 = '0, wr_be1 = '0;
  logic        rd_valid;
  logic [17:0] rd_data0, rd_data1;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [35:0] model [64];
  bit          pv1 = 1'b0, pv2 = 1'b0;
  logic [35:0] pd1 = '0, pd2 = '0;
  string       pt1 = "R3", pt2 = "R3";

  always #4 clk = ~clk;

  burst2_dualport_ram u0 (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_addr(rd_addr), .wr_n(wr_n), .wr_addr(wr_addr),
    .wr_data0(wr_data0), .wr_data1(wr_data1), .wr_be0(wr_be0), .wr_be1(wr_be1),
    .rd_valid(rd_valid), .rd_data0(rd_data0), .rd_data1(rd_data1));

  function automatic logic [35:0] pat(input int a, input int salt);
    logic [17:0] b0, b1;
    b0 = 18'(a * 4099 + salt * 977 + 13) ^ 18'(a << 9);
    b1 = 18'(a * 811 + salt * 5303 + 7) ^ 18'((63 - a) << 11);
    return {b1, b0};
  endfunction

  function automatic logic [35:0] mrg(input logic [35:0] o, input logic [35:0] n, input logic [3:0] m);
    logic [35:0] r;
    r = o;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = n[i*9 +: 9];
    return r;
  endfunction

  task automatic check_out();
    checks++;
    if (pv2) begin
      if (rd_valid !== 1'b1 || {rd_data1, rd_data0} !== pd2) begin
        errors++;
        $display("FAIL %s: valid=%b data=%h expected valid=1 data=%h", pt2, rd_valid, {rd_data1, rd_data0}, pd2);
      end
    end else if (rd_valid !== 1'b0 || {rd_data1, rd_data0} !== 36'h0) begin
      errors++;
      $display("FAIL %s: valid=%b data=%h expected valid=0 data=0", pt2, rd_valid, {rd_data1, rd_data0});
    end
  endtask

  // m bit order: {be1[1], be1[0], be0[1], be0[0]}
  task automatic step(input bit rd, input int ra, input bit wr, input int wa,
                      input logic [35:0] wd, input logic [3:0] m, input string tag);
    check_out();
    rd_n = !rd; rd_addr = 6'(ra);
    wr_n = !wr; wr_addr = 6'(wa);
    {wr_data1, wr_data0} = wd;
    {wr_be1, wr_be0} = m;
    if (wr) model[wa] = mrg(model[wa], wd, m);
    pv2 = pv1; pd2 = pd1; pt2 = pt1;
    pv1 = rd; pd1 = rd ? model[ra] : 36'h0; pt1 = rd ? tag : "R3";
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 36'h0, 4'h0, "R3");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 36'h0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || {rd_data1, rd_data0} !== 36'h0) begin
      errors++;
      $display("FAIL R1: in reset valid=%b data=%h expected 0/0", rd_valid, {rd_data1, rd_data0});
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || {rd_data1, rd_data0} !== 36'h0) begin
      errors++;
      $display("FAIL R1: after reset valid=%b data=%h expected 0/0", rd_valid, {rd_data1, rd_data0});
    end

    // R4: fill every address, then back-to-back reads (R2)
    for (int a = 0; a < 64; a++) step(0, 0, 1, a, pat(a, 1), 4'hF, "R4");
    idle(2);
    for (int a = 0; a < 64; a++) step(1, a, 0, 0, 36'h0, 4'h0, "R2 R4");
    idle(2);

    // R5: all sixteen byte-enable patterns
    for (int a = 0; a < 16; a++) step(0, 0, 1, a, pat(a, 2), 4'(a), "R5");
    idle(2);
    for (int a = 0; a < 16; a++) step(1, a, 0, 0, 36'h0, 4'h0, "R5");

    // R6: read on the cycle after the write, full and partial masks
    for (int a = 0; a < 64; a++) begin
      step(0, 0, 1, a, pat(a, 3), (a % 2 == 0) ? 4'hF : 4'(a % 16), "R6");
      step(1, a, 0, 0, 36'h0, 4'h0, "R6");
    end
    idle(2);

    // R7: same-cycle collision, mask sweep, and pending + same-cycle chain
    for (int a = 0; a < 64; a++) step(1, a, 1, a, pat(a, 4), 4'(15 - (a % 16)), "R7");
    for (int a = 0; a < 16; a++) begin
      step(0, 0, 1, a, pat(a, 5), 4'(a), "R7");
      step(1, a, 1, a, pat(a, 6), 4'(~a), "R7");
    end
    idle(2);
    for (int a = 0; a < 64; a++) step(1, a, 0, 0, 36'h0, 4'h0, "R7");

    // R8: same-cycle read and write to different addresses
    for (int a = 0; a < 64; a++) step(1, a, 1, a ^ 1, pat(a ^ 1, 7), 4'hF, "R8");
    idle(2);
    for (int a = 0; a < 64; a++) step(1, a, 0, 0, 36'h0, 4'h0, "R8");

    // R9: write strobe high with enables set leaves the array unchanged
    for (int a = 0; a < 64; a++) begin
      check_out();
      rd_n = 1'b1; wr_n = 1'b1; wr_addr = 6'(a);
      {wr_data1, wr_data0} = pat(a, 8); {wr_be1, wr_be0} = 4'hF;
      pv2 = pv1; pd2 = pd1; pt2 = pt1; pv1 = 0; pd1 = 0; pt1 = "R9";
      @(negedge clk);
    end
    for (int a = 0; a < 64; a++) step(1, a, 0, 0, 36'h0, 4'h0, "R9");
    idle(3);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule